// File: doc/BRIEF.md
# Fixed-Frame Delta-Sigma ADC SPI Engine

This block is an SPI master that runs one full-duplex frame to a simultaneous-sampling delta-sigma converter with `NUM_CH` channels, where `NUM_CH` is 2 to 8. A frame always has `NUM_CH + 2` words of 24 bits. The host supplies a 16-bit command and, for register writes, a 16-bit data word. The block builds the transmit frame and appends an input CRC. It shifts the frame out on MOSI and captures the frame coming back on MISO at the same time.

At the end of the frame the block checks the output CRC sent by the converter. It then presents the response word, every channel sample sign-extended to 32 bits, and an error flag. The transfer is full duplex, so the response seen in one frame answers the command sent in the frame before it. Sequencing register accesses across frames is the caller's job.

Top module: `adc_frame_spi`

## Requirements
- R1: One frame drives chip select low for exactly (NUM_CH+2)*24 SCLK periods. No other frame starts until the `done` pulse.
- R2: Transmit word 0 is the command in bits 23:8 and zero in bits 7:0, sent MSB first. Every transmit word after the CRC word is all zeros.
- R3: When `wdata_en` is 0, transmit word 1 carries the CRC of the 3 bytes of word 0 in bits 23:8 and zero in bits 7:0.
- R4: When `wdata_en` is 1, transmit word 1 is the data in bits 23:8 and zero below. Word 2 carries the CRC of the 6 bytes of words 0 and 1 in bits 23:8 and zero below.
- R5: Every CRC is computed MSB first over bytes. It uses generator x^16+x^12+x^5+1 (0x1021) and starts from 0xFFFF.
- R6: Received word 0 is the response, and `resp_out` is its bits 23:8. Received words 1 to NUM_CH are channels 0 to NUM_CH-1. The last received word is the CRC word.
- R7: `samples_out[32k+31:32k]` is received channel k as a two's complement value, sign-extended from bit 23.
- R8: `crc_err` is 1 exactly when bits 23:8 of the last received word differ from the CRC of the first (NUM_CH+1)*3 received bytes.
- R9: SPI mode 1 is used. SCLK idles low, and MOSI changes only on rising SCLK edges. MISO is sampled on falling edges. Each SCLK level lasts `CLK_DIV` system clocks.
- R10: `start` is accepted only when `busy` is 0, and a `start` during a frame is ignored. `done` is a single-cycle pulse one clock after chip select returns high. Results are valid from that pulse onward.
- R11: While `rst_n` is low at a clock edge, the block drives `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0, `done`=0 and `crc_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one frame |
| cmd_in | input | 16 | Command for word 0 |
| wdata_in | input | 16 | Data for word 1 when `wdata_en` is 1 |
| wdata_en | input | 1 | Frame carries a data word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |
| resp_out | output | 16 | Response word, upper 16 bits |
| samples_out | output | NUM_CH*32 | Sign-extended channel samples, channel 0 at LSB |
| crc_err | output | 1 | Output CRC mismatch on the last frame |

## Verification
A wrong bit counter shows up at the ports in the same frame: the number of SCLK rises is wrong, and the `done` pulse comes too early or too late. A faulty CRC register or wrong byte coverage makes the transmitted CRC word differ from the expected value within that frame. On the receive side it raises or drops `crc_err` at the next `done`. A misplaced channel slice or a bad sign extension is visible in `samples_out` at the first `done` after a frame that carries negative and positive samples.

// File: rtl/adcf_pkg.sv
// Package: shared CRC helpers and sequencer state for the ADC frame engine.
// Assumes CRC-16 with generator 0x1021, MSB-first, processed one bit at a time.
package adcf_pkg;

    localparam int WORD_BITS = 24;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_t;

    // Advance the CRC by one serial bit.
    function automatic logic [15:0] crc16_bit(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    // Advance the CRC by one byte, MSB first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) r = crc16_bit(r, d[i]);
        return r;
    endfunction

endpackage

// File: rtl/adcf_tx_build.sv
// Transmit frame builder: places the command, optional data word and input
// CRC into a fixed (NUM_CH+2)-word frame. All remaining words are zero.
// Assumes NUM_CH >= 2, so the frame always has room for three leading words.
module adcf_tx_build
    import adcf_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int WORDS = NUM_CH + 2,
    localparam int TOTAL_BITS = WORDS * WORD_BITS
) (
    input  logic [15:0]           cmd_in,
    input  logic [15:0]           wdata_in,
    input  logic                  wdata_en,
    output logic [TOTAL_BITS-1:0] frame_out
);

    logic [15:0] crc_cmd;
    logic [15:0] crc_cmd_data;

    // Input CRC over word 0 alone, and over words 0 and 1.
    always_comb begin
        crc_cmd      = crc16_byte(crc16_byte(crc16_byte(16'hFFFF, cmd_in[15:8]), cmd_in[7:0]), 8'h00);
        crc_cmd_data = crc16_byte(crc16_byte(crc16_byte(crc_cmd, wdata_in[15:8]), wdata_in[7:0]), 8'h00);
    end

    // Each word slot picks its content from its position and the frame kind.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [23:0] word;
        always_comb begin
            word = 24'h0;
            if (w == 0)                  word = {cmd_in, 8'h00};
            else if (w == 1 && wdata_en) word = {wdata_in, 8'h00};
            else if (w == 1)             word = {crc_cmd, 8'h00};
            else if (w == 2 && wdata_en) word = {crc_cmd_data, 8'h00};
        end
        assign frame_out[TOTAL_BITS-1-w*WORD_BITS -: WORD_BITS] = word;
    end

endmodule

// File: rtl/adcf_seq.sv
// Frame sequencer: SCLK divider, chip select, MOSI shifter and handshake.
// SPI mode 1: MOSI changes on rising SCLK, MISO sampled on falling SCLK.
// Assumes CLK_DIV >= 1 system clocks per SCLK level.
module adcf_seq
    import adcf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CLK_DIV = 2,
    localparam int TOTAL_BITS = (NUM_CH + 2) * WORD_BITS,
    localparam int BW = $clog2(TOTAL_BITS),
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [TOTAL_BITS-1:0] frame_in,
    output logic                  busy,
    output logic                  done,
    output logic                  sclk,
    output logic                  cs_n,
    output logic                  mosi,
    output logic                  load_stb,
    output logic                  smp_stb,
    output logic                  fin_stb
);

    seq_state_t            state;
    logic [DW-1:0]         div_cnt;
    logic [BW-1:0]         bit_cnt;
    logic [TOTAL_BITS-1:0] tx_sr;
    logic                  tick;

    // Strobes decoded from the current state for the receive side.
    always_comb begin
        tick     = (div_cnt == DW'(CLK_DIV - 1));
        load_stb = (state == ST_IDLE) && start;
        smp_stb  = (state == ST_SHIFT) && tick && sclk;
        fin_stb  = (state == ST_FIN);
        busy     = (state != ST_IDLE);
    end

    // Half-period divider, running only while a frame is active.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE || state == ST_FIN || tick) div_cnt <= '0;
        else                                                      div_cnt <= div_cnt + 1'b1;
    end

    // Frame state machine, SCLK generation and MOSI shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            mosi    <= 1'b0;
            done    <= 1'b0;
            bit_cnt <= '0;
            tx_sr   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    tx_sr   <= frame_in;
                    cs_n    <= 1'b0;
                    bit_cnt <= '0;
                    state   <= ST_SHIFT;
                end
                ST_SHIFT: if (tick) begin
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        mosi  <= tx_sr[TOTAL_BITS-1];
                        tx_sr <= {tx_sr[TOTAL_BITS-2:0], 1'b0};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_cnt == BW'(TOTAL_BITS - 1)) state <= ST_TAIL;
                        else                                bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_TAIL: if (tick) begin
                    cs_n  <= 1'b1;
                    mosi  <= 1'b0;
                    state <= ST_FIN;
                end
                default: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R9
    AST_MOSI_HOLD_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk) |-> $stable(mosi)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && !busy)); // R10
    AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) bit_cnt < BW'(TOTAL_BITS)); // R1

endmodule

// File: rtl/adcf_rx_check.sv
// Receive side: captures MISO, runs the output CRC serially over the response
// and channel words, and latches response, samples and error at frame end.
// Assumes smp_stb fires once per falling SCLK edge of the frame.
module adcf_rx_check
    import adcf_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int TOTAL_BITS = (NUM_CH + 2) * WORD_BITS,
    localparam int CRC_BITS = (NUM_CH + 1) * WORD_BITS,
    localparam int CW = $clog2(TOTAL_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_stb,
    input  logic                  smp_stb,
    input  logic                  fin_stb,
    input  logic                  miso,
    output logic [15:0]           resp_out,
    output logic [NUM_CH*32-1:0]  samples_out,
    output logic                  crc_err
);

    logic [TOTAL_BITS-1:0] rx_sr;
    logic [15:0]           crc;
    logic [CW-1:0]         cnt;

    // Shift in MISO and fold the covered bits into the running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
            crc   <= 16'hFFFF;
            cnt   <= '0;
        end else if (load_stb) begin
            crc <= 16'hFFFF;
            cnt <= '0;
        end else if (smp_stb) begin
            rx_sr <= {rx_sr[TOTAL_BITS-2:0], miso};
            cnt   <= cnt + 1'b1;
            if (cnt < CW'(CRC_BITS)) crc <= crc16_bit(crc, miso);
        end
    end

    // Latch the response word and the CRC verdict at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_out <= '0;
            crc_err  <= 1'b0;
        end else if (fin_stb) begin
            resp_out <= rx_sr[TOTAL_BITS-1 -: 16];
            crc_err  <= (crc != rx_sr[23:8]);
        end
    end

    // One sign-extending result register per channel.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam int HI = TOTAL_BITS - 1 - (k + 1) * WORD_BITS;
        // Latch channel k at frame end.
        always_ff @(posedge clk) begin
            if (!rst_n)       samples_out[k*32 +: 32] <= '0;
            else if (fin_stb) samples_out[k*32 +: 32] <= {{8{rx_sr[HI]}}, rx_sr[HI -: 24]};
        end
    end

    AST_RX_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(TOTAL_BITS)); // R1
    AST_RX_FULL_AT_END: assert property (@(posedge clk) disable iff (!rst_n) fin_stb |-> cnt == CW'(TOTAL_BITS)); // R1

endmodule

// File: rtl/adc_frame_spi.sv
// Top: fixed-frame full-duplex SPI engine for a NUM_CH-channel converter.
// Builds the command frame with input CRC, shifts it while capturing the
// reply, checks the output CRC and presents sign-extended samples.
// Assumes 2 <= NUM_CH <= 8 and that the caller holds inputs stable at start.
module adc_frame_spi
    import adcf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CLK_DIV = 2,
    localparam int TOTAL_BITS = (NUM_CH + 2) * WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [15:0]          cmd_in,
    input  logic [15:0]          wdata_in,
    input  logic                 wdata_en,
    output logic                 busy,
    output logic                 done,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi,
    input  logic                 miso,
    output logic [15:0]          resp_out,
    output logic [NUM_CH*32-1:0] samples_out,
    output logic                 crc_err
);

    logic [TOTAL_BITS-1:0] frame;
    logic                  load_stb, smp_stb, fin_stb;

    adcf_tx_build #(.NUM_CH(NUM_CH)) u_tx (
        .cmd_in(cmd_in), .wdata_in(wdata_in), .wdata_en(wdata_en), .frame_out(frame)
    );

    adcf_seq #(.NUM_CH(NUM_CH), .CLK_DIV(CLK_DIV)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame),
        .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .load_stb(load_stb), .smp_stb(smp_stb), .fin_stb(fin_stb)
    );

    adcf_rx_check #(.NUM_CH(NUM_CH)) u_rx (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .smp_stb(smp_stb),
        .fin_stb(fin_stb), .miso(miso), .resp_out(resp_out),
        .samples_out(samples_out), .crc_err(crc_err)
    );

endmodule

// File: tb/adc_frame_spi_test.sv
// Directed bench with a behavioural mode-1 converter model on the SPI pins.
module adc_frame_spi_test;

    localparam int NCH = 4;
    localparam int DIV = 2;
    localparam int TB = (NCH + 2) * 24;
    localparam int CB = (NCH + 1) * 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] cmd_in = '0, wdata_in = '0;
    logic wdata_en = 1'b0;
    logic busy, done, sclk, cs_n, mosi;
    logic miso = 1'b0;
    logic [15:0] resp_out;
    logic [NCH*32-1:0] samples_out;
    logic crc_err;

    int total = 0, bad = 0, cycles = 0;
    logic [TB-1:0] slv_frame = '0;
    logic [TB-1:0] slv_sr = '0;
    logic [TB-1:0] cap = '0;
    int rise_cnt = 0, cs_falls = 0;

    always #10 clk = ~clk;

    adc_frame_spi #(.NUM_CH(NCH), .CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd_in), .wdata_in(wdata_in),
        .wdata_en(wdata_en), .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .resp_out(resp_out), .samples_out(samples_out),
        .crc_err(crc_err)
    );

    // Converter model: load on chip-select fall, drive MISO on rising SCLK.
    always @(negedge cs_n or posedge sclk) begin
        if (sclk) begin
            miso     <= slv_sr[TB-1];
            slv_sr   <= {slv_sr[TB-2:0], 1'b0};
            rise_cnt <= rise_cnt + 1;
        end else begin
            slv_sr   <= slv_frame;
            rise_cnt <= 0;
            cs_falls <= cs_falls + 1;
        end
    end

    // Converter model: capture MOSI on falling SCLK.
    always @(negedge sclk) cap <= {cap[TB-2:0], mosi};

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1; total = total + 1;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] ref_crc(input logic [TB-1:0] v, input int nbits);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < nbits; i++) begin
            logic fb = c[15] ^ v[TB-1-i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Build a converter reply: response, channel words, CRC (optionally broken).
    function automatic logic [TB-1:0] mk_reply(input logic [15:0] resp, input logic [23:0] s0,
        input logic [23:0] s1, input logic [23:0] s2, input logic [23:0] s3, input logic corrupt);
        logic [TB-1:0] f;
        logic [15:0] c;
        f = {resp, 8'h00, s0, s1, s2, s3, 24'h0};
        c = ref_crc(f, CB) ^ (corrupt ? 16'h0100 : 16'h0000);
        f[23:8] = c;
        return f;
    endfunction

    // Run one frame; checks handshake timing, frame length and SCLK half period.
    task automatic run_frame(input logic [15:0] cmd, input logic [15:0] dat, input logic den,
                             input logic poke_start);
        int hi_cnt = 0, guard = 0;
        logic prev_cs = 1'b1;
        int falls0 = cs_falls;
        @(negedge clk);
        cmd_in = cmd; wdata_in = dat; wdata_en = den; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", 64'(busy), 64'd1);
        if (sclk) hi_cnt++;
        while (!done && guard < 5000) begin
            prev_cs = cs_n;
            @(negedge clk);
            guard++;
            if (sclk) hi_cnt++;
            if (poke_start && guard == 100) start = 1'b1;
            if (poke_start && guard == 101) start = 1'b0;
        end
        check("R10 cs_n high before done", 64'(prev_cs), 64'd1);
        check("R1 sclk rises per frame", 64'(rise_cnt), 64'(TB));
        check("R9 sclk high cycles", 64'(hi_cnt), 64'(TB * DIV));
        check("R1 one cs assertion", 64'(cs_falls - falls0), 64'd1);
        @(negedge clk);
        check("R10 done single cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R11 cs_n", 64'(cs_n), 64'd1);
        check("R11 sclk", 64'(sclk), 64'd0);
        check("R11 mosi", 64'(mosi), 64'd0);
        check("R11 busy", 64'(busy), 64'd0);
        check("R11 done", 64'(done), 64'd0);
        check("R11 crc_err", 64'(crc_err), 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_null_cmd();
        logic [TB-1:0] exp = '0;
        slv_frame = mk_reply(16'h0500, 24'h000123, 24'hFFFFFE, 24'h7FFFFF, 24'h800000, 1'b0);
        run_frame(16'h0000, 16'h0000, 1'b0, 1'b0);
        exp[TB-1 -: 24] = 24'h0;
        exp[TB-25 -: 16] = ref_crc(exp, 24);
        check("R2 R3 R5 null tx frame", 64'(cap != exp), 64'd0);
        check("R6 response", 64'(resp_out), 64'h0500);
        check("R7 ch0 positive", 64'(samples_out[31:0]), 64'h00000123);
        check("R7 ch1 negative", 64'(samples_out[63:32]), 64'hFFFFFFFE);
        check("R7 ch2 max", 64'(samples_out[95:64]), 64'h007FFFFF);
        check("R7 ch3 min", 64'(samples_out[127:96]), 64'hFF800000);
        check("R8 good crc", 64'(crc_err), 64'd0);
    endtask

    task automatic t_read_cmd();
        logic [TB-1:0] exp = '0;
        slv_frame = mk_reply(16'hFF24, 24'hABCDEF, 24'h012345, 24'h000000, 24'hFEDCBA, 1'b0);
        run_frame(16'hA100, 16'h5A5A, 1'b0, 1'b0);
        exp[TB-1 -: 24] = 24'hA10000;
        exp[TB-25 -: 16] = ref_crc(exp, 24);
        check("R2 R3 command frame", 64'(cap != exp), 64'd0);
        check("R2 low byte word0", 64'(cap[TB-17 -: 8]), 64'h00);
        check("R6 response", 64'(resp_out), 64'hFF24);
        check("R7 ch0", 64'(samples_out[31:0]), 64'hFFABCDEF);
        check("R7 ch3", 64'(samples_out[127:96]), 64'hFFFEDCBA);
    endtask

    task automatic t_write_cmd();
        logic [TB-1:0] exp = '0;
        slv_frame = mk_reply(16'h4100, 24'h000001, 24'h000002, 24'h000003, 24'h000004, 1'b0);
        run_frame(16'h6100, 16'h1F3C, 1'b1, 1'b0);
        exp[TB-1 -: 24] = 24'h610000;
        exp[TB-25 -: 24] = 24'h1F3C00;
        exp[TB-49 -: 16] = ref_crc(exp, 48);
        check("R4 R5 write frame", 64'(cap != exp), 64'd0);
        check("R2 trailing words zero", 64'(cap[TB-73:0] == '0), 64'd1);
        check("R8 good crc", 64'(crc_err), 64'd0);
    endtask

    task automatic t_crc_bad();
        slv_frame = mk_reply(16'h0500, 24'h111111, 24'h222222, 24'h333333, 24'h444444, 1'b1);
        run_frame(16'h0000, 16'h0000, 1'b0, 1'b0);
        check("R8 corrupted crc flagged", 64'(crc_err), 64'd1);
        slv_frame = mk_reply(16'h0500, 24'h111111, 24'h222222, 24'h333333, 24'h444444, 1'b0);
        run_frame(16'h0000, 16'h0000, 1'b0, 1'b0);
        check("R8 flag clears on good crc", 64'(crc_err), 64'd0);
    endtask

    task automatic t_busy_start();
        int falls0 = cs_falls;
        slv_frame = mk_reply(16'h0001, 24'h0, 24'h0, 24'h0, 24'h0, 1'b0);
        run_frame(16'h0000, 16'h0000, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        check("R10 start during frame ignored", 64'(cs_falls - falls0), 64'd1);
        check("R10 idle after frame", 64'(busy), 64'd0);
        check("R9 sclk idle low", 64'(sclk), 64'd0);
    endtask

    initial begin
        t_reset();
        t_null_cmd();
        t_read_cmd();
        t_write_cmd();
        t_crc_bad();
        t_busy_start();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule